// File: doc/BRIEF.md
# Actuator Driver Power-State Controller

This block sequences the power modes of a low-power actuator driver. A single state register moves between five modes: off, waking, idle, bus-busy idle and playing. An active-low reset pin forces the off mode at once and aborts whatever is in progress. A supply-good flag pulls every powered mode back to off. A wake-up phase of fixed length ends with a one-cycle pulse that tells the rest of the chip to reload its default settings.

In the idle modes the block follows three kinds of traffic. Serial-bus transaction strobes move it between idle and bus-busy idle. A waveform trigger starts playback from either idle mode. A waveform-finished indication or a critical fault returns it from playback to idle. The outputs are a one-hot mode indication, an enable for the bus controller, the reload pulse and an enable for the output stage.

Only the release edge of the reset pin is synchronised. If the pin is tied high, the block starts waking as soon as the supply-good flag rises.

Top module: `hap_pwr_ctrl`

## Requirements
- R1: While the reset pin is low, the mode is off and the bus, reload and output-stage outputs are all low. Driving the pin low takes effect without waiting for a clock edge.
- R2: In the off mode, bus_en_o, drv_en_o and load_dflt_o are all low.
- R3: Waking begins on the third rising edge after the reset pin is released, provided the supply-good flag is high. With the pin held high, waking begins one edge after the supply-good flag is seen high.
- R4: Waking lasts at least PWRUP_CYCLES cycles (default 16) and continues while pwr_ready_i is low. The block then enters idle, and load_dflt_o is high for exactly the first idle cycle.
- R5: If por_ok_i is low at a rising edge, the next mode is off, whatever the current mode and whatever else is requested.
- R6: A waveform trigger in idle or bus-busy idle moves the block to playing. The trigger wins over a bus strobe in the same cycle.
- R7: A bus start strobe in idle moves the block to bus-busy idle, and a bus done strobe there returns it to idle. Bus strobes have no effect in any other mode.
- R8: In playing, a critical fault or a waveform-finished indication returns the block to idle at the next edge. Triggers and bus strobes have no effect while playing.
- R9: state_oh_o is one-hot: bit 0 off, bit 1 waking, bit 2 idle, bit 3 bus-busy idle, bit 4 playing. bus_en_o is high in idle, bus-busy idle and playing. drv_en_o is high only in playing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| sys_rst_ni | input | 1 | Chip-level asynchronous reset, active low |
| pin_rst_ni | input | 1 | External reset pin, active low; assertion is asynchronous |
| por_ok_i | input | 1 | Supply-good flag from power-on-reset logic |
| pwr_ready_i | input | 1 | Analog supplies report ready |
| wave_trig_i | input | 1 | Waveform trigger |
| wave_done_i | input | 1 | Waveform playback finished |
| crit_fault_i | input | 1 | Critical condition |
| bus_start_i | input | 1 | Serial-bus transaction started |
| bus_done_i | input | 1 | Serial-bus transaction finished |
| state_oh_o | output | 5 | One-hot mode indication |
| bus_en_o | output | 1 | Bus controller enable |
| load_dflt_o | output | 1 | One-cycle default-reload pulse |
| drv_en_o | output | 1 | Output stage enable |

## Verification
The hardest situations to reach from the ports are a supply drop or a pin assertion that lands in the middle of waking, and a waking phase stretched by a late ready. In both, the wake counter must restart cleanly on the next attempt. The stimulus mixes rare random pin and supply drops with frequent triggers and strobes, so aborts land in every mode, including partway through waking. Directed sequences cover the exact wake length, a stretched wake, conflicting strobes in the same cycle, and the pin-tied-high start path.

// File: rtl/hpc_pkg.sv
package hpc_pkg;

    typedef enum logic [2:0] {
        ST_OFF      = 3'd0,
        ST_WAKE     = 3'd1,
        ST_IDLE     = 3'd2,
        ST_BUS_IDLE = 3'd3,
        ST_PLAY     = 3'd4
    } pstate_e;

    localparam int unsigned NUM_STATES = 5;

    typedef struct packed {
        pstate_e state;
        logic    load;
    } fsm_regs_t;

endpackage

// File: rtl/hpc_rst_sync.sv
module hpc_rst_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk_i,
    input  logic arst_ni,
    output logic rel_o
);
    logic [STAGES-1:0] stage_d, stage_q;

    generate
        if (STAGES > 1) begin : g_multi
            always_comb stage_d = {stage_q[STAGES-2:0], 1'b1};
        end else begin : g_single
            always_comb stage_d = 1'b1;
        end
    endgenerate

    always_ff @(posedge clk_i or negedge arst_ni) begin
        if (!arst_ni) stage_q <= '0;
        else          stage_q <= stage_d;
    end

    assign rel_o = stage_q[STAGES-1];
endmodule

// File: rtl/hpc_wake_timer.sv
module hpc_wake_timer #(
    parameter int unsigned CYCLES = 16
) (
    input  logic clk_i,
    input  logic arst_ni,
    input  logic run_i,
    output logic done_o
);
    localparam int unsigned CW = (CYCLES > 1) ? $clog2(CYCLES) : 1;
    localparam logic [CW-1:0] LAST = CW'(CYCLES - 1);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        if (!run_i)             cnt_d = '0;
        else if (cnt_q == LAST) cnt_d = cnt_q;
        else                    cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk_i or negedge arst_ni) begin
        if (!arst_ni) cnt_q <= '0;
        else          cnt_q <= cnt_d;
    end

    assign done_o = (cnt_q == LAST);
endmodule

// File: rtl/hap_pwr_ctrl.sv
module hap_pwr_ctrl
    import hpc_pkg::*;
#(
    parameter int unsigned PWRUP_CYCLES = 16,
    parameter int unsigned SYNC_STAGES  = 2
) (
    input  logic       clk_i,
    input  logic       sys_rst_ni,
    input  logic       pin_rst_ni,
    input  logic       por_ok_i,
    input  logic       pwr_ready_i,
    input  logic       wave_trig_i,
    input  logic       wave_done_i,
    input  logic       crit_fault_i,
    input  logic       bus_start_i,
    input  logic       bus_done_i,
    output logic [4:0] state_oh_o,
    output logic       bus_en_o,
    output logic       load_dflt_o,
    output logic       drv_en_o
);
    logic      arst_n;
    logic      rel;
    logic      wake_done;
    fsm_regs_t regs_d, regs_q;

    // pin assertion acts on the flops directly; only its release is synchronised
    assign arst_n = sys_rst_ni & pin_rst_ni;

    hpc_rst_sync #(.STAGES(SYNC_STAGES)) i_rst_sync (
        .clk_i   (clk_i),
        .arst_ni (arst_n),
        .rel_o   (rel)
    );

    hpc_wake_timer #(.CYCLES(PWRUP_CYCLES)) i_wake_timer (
        .clk_i   (clk_i),
        .arst_ni (arst_n),
        .run_i   (regs_q.state == ST_WAKE),
        .done_o  (wake_done)
    );

    always_comb begin
        regs_d      = regs_q;
        regs_d.load = 1'b0;
        if (!rel || !por_ok_i) begin
            regs_d.state = ST_OFF;
        end else begin
            case (regs_q.state)
                ST_OFF:  regs_d.state = ST_WAKE;
                ST_WAKE: begin
                    if (wake_done && pwr_ready_i) begin
                        regs_d.state = ST_IDLE;
                        regs_d.load  = 1'b1;
                    end
                end
                ST_IDLE: begin
                    if (wave_trig_i)      regs_d.state = ST_PLAY;
                    else if (bus_start_i) regs_d.state = ST_BUS_IDLE;
                end
                ST_BUS_IDLE: begin
                    if (wave_trig_i)     regs_d.state = ST_PLAY;
                    else if (bus_done_i) regs_d.state = ST_IDLE;
                end
                ST_PLAY: begin
                    if (crit_fault_i)     regs_d.state = ST_IDLE;
                    else if (wave_done_i) regs_d.state = ST_IDLE;
                end
                default: regs_d.state = ST_OFF;
            endcase
        end
    end

    always_ff @(posedge clk_i or negedge arst_n) begin
        if (!arst_n) begin
            regs_q.state <= ST_OFF;
            regs_q.load  <= 1'b0;
        end else begin
            regs_q <= regs_d;
        end
    end

    generate
        for (genvar i = 0; i < NUM_STATES; i++) begin : g_oh
            assign state_oh_o[i] = (regs_q.state == pstate_e'(3'(i)));
        end
    endgenerate

    assign bus_en_o    = (regs_q.state == ST_IDLE) || (regs_q.state == ST_BUS_IDLE) ||
                         (regs_q.state == ST_PLAY);
    assign drv_en_o    = (regs_q.state == ST_PLAY);
    assign load_dflt_o = regs_q.load;
endmodule

// File: rtl/hap_pwr_ctrl_chk.sv
module hap_pwr_ctrl_chk (
    input logic       clk_i,
    input logic       sys_rst_ni,
    input logic       pin_rst_ni,
    input logic       por_ok_i,
    input logic       crit_fault_i,
    input logic       wave_done_i,
    input logic [4:0] state_oh_o,
    input logic       bus_en_o,
    input logic       load_dflt_o,
    input logic       drv_en_o
);
    logic arst_n;
    assign arst_n = sys_rst_ni & pin_rst_ni;

    // R1
    pin_abort_chk: assert property (@(posedge clk_i) disable iff (!sys_rst_ni)
        !pin_rst_ni |-> (state_oh_o[0] && !drv_en_o && !bus_en_o));

    // R2
    off_quiet_chk: assert property (@(posedge clk_i) disable iff (!arst_n)
        state_oh_o[0] |-> (!bus_en_o && !drv_en_o && !load_dflt_o));

    // R4
    load_after_wake_chk: assert property (@(posedge clk_i) disable iff (!arst_n)
        load_dflt_o |-> (state_oh_o[2] && $past(state_oh_o[1])));

    // R5
    supply_drop_chk: assert property (@(posedge clk_i) disable iff (!arst_n)
        !por_ok_i |=> state_oh_o[0]);

    // R7
    bus_entry_chk: assert property (@(posedge clk_i) disable iff (!arst_n)
        (state_oh_o[3] && !$past(state_oh_o[3])) |-> $past(state_oh_o[2]));

    // R8
    play_exit_chk: assert property (@(posedge clk_i) disable iff (!arst_n)
        (state_oh_o[4] && por_ok_i && (crit_fault_i || wave_done_i)) |=> state_oh_o[2]);

    // R9
    onehot_chk: assert property (@(posedge clk_i) disable iff (!arst_n)
        $countones(state_oh_o) == 1);
endmodule

bind hap_pwr_ctrl hap_pwr_ctrl_chk i_chk (
    .clk_i        (clk_i),
    .sys_rst_ni   (sys_rst_ni),
    .pin_rst_ni   (pin_rst_ni),
    .por_ok_i     (por_ok_i),
    .crit_fault_i (crit_fault_i),
    .wave_done_i  (wave_done_i),
    .state_oh_o   (state_oh_o),
    .bus_en_o     (bus_en_o),
    .load_dflt_o  (load_dflt_o),
    .drv_en_o     (drv_en_o)
);

// File: tb/test_hap_pwr_ctrl.sv
`timescale 1ns/1ps
module test_hap_pwr_ctrl;
    localparam int N    = 16;
    localparam int SYNC = 2;
    localparam int M_OFF = 0, M_WAKE = 1, M_IDLE = 2, M_BUS = 3, M_PLAY = 4;

    logic clk = 1'b0;
    logic sys_rst_n = 1'b0, pin_n = 1'b1, por = 1'b1, rdy = 1'b1;
    logic trg = 1'b0, wfd = 1'b0, flt = 1'b0, bs = 1'b0, bd = 1'b0;
    logic [4:0] oh;
    logic bus_en, load, drv;

    int checks = 0, errors = 0;
    int m_state = M_OFF, m_sync = 0, m_cnt = 0;
    bit m_load = 1'b0;

    always #2.5 clk = ~clk;

    hap_pwr_ctrl #(.PWRUP_CYCLES(N), .SYNC_STAGES(SYNC)) i_hap_pwr_ctrl (
        .clk_i(clk), .sys_rst_ni(sys_rst_n), .pin_rst_ni(pin_n), .por_ok_i(por),
        .pwr_ready_i(rdy), .wave_trig_i(trg), .wave_done_i(wfd), .crit_fault_i(flt),
        .bus_start_i(bs), .bus_done_i(bd), .state_oh_o(oh), .bus_en_o(bus_en),
        .load_dflt_o(load), .drv_en_o(drv)
    );

    function automatic logic [7:0] expect_vec(int st, bit ld);
        logic [4:0] e_oh;
        e_oh = 5'b00001 << st;
        return {e_oh, (st == M_IDLE || st == M_BUS || st == M_PLAY), (st == M_PLAY), ld};
    endfunction

    function automatic int next_mode(int st, int cnt, bit r, bit t, bit d, bit f, bit s, bit e);
        case (st)
            M_OFF:  return M_WAKE;
            M_WAKE: return (cnt == N-1 && r) ? M_IDLE : M_WAKE;
            M_IDLE: return t ? M_PLAY : (s ? M_BUS : M_IDLE);
            M_BUS:  return t ? M_PLAY : (e ? M_IDLE : M_BUS);
            default: return (f || d) ? M_IDLE : M_PLAY;
        endcase
    endfunction

    task automatic check(string tag, logic [7:0] got, logic [7:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got {oh,bus,drv,load}=%b expected %b", tag, got, exp);
        end
    endtask

    // called just after a falling edge; applies inputs, advances one rising edge, checks
    task automatic step(string tag, bit p, bit o, bit r, bit t, bit d, bit f, bit s, bit e);
        bit rel;
        int ns;
        bit nl;
        pin_n = p; por = o; rdy = r; trg = t; wfd = d; flt = f; bs = s; bd = e;
        if (!p) begin
            m_state = M_OFF; m_sync = 0; m_cnt = 0; m_load = 1'b0;
            #0.5;
            check("R1 immediate abort", {oh, bus_en, drv, load}, expect_vec(M_OFF, 1'b0));
        end
        rel = p && (m_sync >= SYNC);
        nl  = 1'b0;
        if (!rel || !o) ns = M_OFF;
        else begin
            ns = next_mode(m_state, m_cnt, r, t, d, f, s, e);
            nl = (m_state == M_WAKE && ns == M_IDLE);
        end
        if (m_state == M_WAKE) m_cnt = (m_cnt == N-1) ? m_cnt : m_cnt + 1;
        else                   m_cnt = 0;
        m_sync  = p ? ((m_sync < SYNC) ? m_sync + 1 : SYNC) : 0;
        m_state = ns;
        m_load  = nl;
        @(posedge clk);
        #1;
        check(tag, {oh, bus_en, drv, load}, expect_vec(m_state, m_load));
        @(negedge clk);
    endtask

    task automatic quiet(string tag, int n);
        for (int i = 0; i < n; i++) step(tag, 1, 1, 1, 0, 0, 0, 0, 0);
    endtask

    initial begin
        #1_000_000;
        errors++; checks++;
        $display("FAIL watchdog: run did not complete, expected completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        int wake_len;
        void'($urandom(32'h5eed_1234));
        repeat (3) @(negedge clk);
        #0.5;
        check("R2 reset state", {oh, bus_en, drv, load}, expect_vec(M_OFF, 1'b0));
        sys_rst_n = 1'b1;

        // R3: two edges still off, third edge enters waking
        step("R3 sync edge 1", 1, 1, 1, 0, 0, 0, 0, 0);
        step("R3 sync edge 2", 1, 1, 1, 0, 0, 0, 0, 0);
        step("R3 wake entry", 1, 1, 1, 0, 0, 0, 0, 0);
        // R4: count waking cycles until idle
        wake_len = 1;
        while (oh[1] && wake_len < 100) begin
            step("R4 waking", 1, 1, 1, 0, 0, 0, 0, 0);
            if (oh[1]) wake_len++;
        end
        checks++;
        if (wake_len != N) begin
            errors++;
            $display("FAIL R4 wake length: got %0d expected %0d", wake_len, N);
        end
        checks++;
        if (load !== 1'b1) begin
            errors++;
            $display("FAIL R4 reload pulse: got %b expected 1", load);
        end
        step("R4 pulse ends", 1, 1, 1, 0, 0, 0, 0, 0);

        // R7 / R6 in the idle modes
        step("R7 bus start", 1, 1, 1, 0, 0, 0, 1, 0);
        step("R7 start ignored in bus idle", 1, 1, 1, 0, 0, 0, 1, 0);
        step("R6 trig beats bus done", 1, 1, 1, 1, 0, 0, 0, 1);
        // R8: strobes ignored while playing, fault returns to idle
        step("R8 strobes ignored", 1, 1, 1, 1, 0, 0, 1, 1);
        step("R8 fault exit", 1, 1, 1, 0, 0, 1, 0, 0);
        step("R6 trig beats bus start", 1, 1, 1, 1, 0, 0, 1, 0);
        step("R8 finished exit", 1, 1, 1, 0, 1, 0, 0, 0);
        step("R7 done ignored in idle", 1, 1, 1, 0, 0, 0, 0, 1);

        // R5: supply drop while playing, then pin-tied-high restart (R3)
        step("R6 trig", 1, 1, 1, 1, 0, 0, 0, 0);
        step("R5 supply drop beats trigger", 1, 0, 1, 1, 0, 0, 0, 0);
        step("R3 tied pin restart", 1, 1, 0, 0, 0, 0, 0, 0);
        // R4: ready low stretches waking
        quiet("R4 waking", N - 1);
        step("R4 stretched by ready", 1, 1, 0, 0, 0, 0, 0, 0);
        step("R4 stretched by ready", 1, 1, 0, 0, 0, 0, 0, 0);
        step("R4 ready exit", 1, 1, 1, 0, 0, 0, 0, 0);
        step("R6 trig", 1, 1, 1, 1, 0, 0, 0, 0);
        // R1: pin asserted during playback
        step("R1 pin abort", 0, 1, 1, 0, 0, 0, 0, 0);
        step("R2 held off", 0, 1, 1, 1, 0, 0, 1, 0);
        quiet("R3 release", 3);
        step("R5 abort mid wake", 1, 0, 1, 0, 0, 0, 0, 0);
        quiet("R4 rewake", N + 2);

        // random mix checked against the bench model (R1..R9)
        for (int i = 0; i < 6000; i++) begin
            step("R9 random model",
                 ($urandom_range(0, 79) != 0), ($urandom_range(0, 59) != 0),
                 ($urandom_range(0, 3) != 0),  ($urandom_range(0, 7) == 0),
                 ($urandom_range(0, 5) == 0),  ($urandom_range(0, 11) == 0),
                 ($urandom_range(0, 4) == 0),  ($urandom_range(0, 4) == 0));
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule